// File: doc/BRIEF.md
# Paged GPIO Edge-Interrupt Controller

This block is a 48-line general-purpose I/O peripheral on a small byte-wide register bus with a 4-bit address and separate write and read strobes. The lines are grouped into six 8-bit ports. Each port has an output latch that drives its pins and a readback path that returns the synchronized pin levels.

The lowest three ports (lines 0 to 23) also capture edges. Every one of these lines has an enable bit, a polarity bit and a sticky event flag. The three banks share one three-register window, and a page register chooses which bank that window shows. A summary register reports which interrupt-capable ports hold at least one event. A single interrupt output is high whenever any event is latched.

Software acknowledges an event by writing the line's enable bit to 0 and then back to 1 while the enable page is selected. While the enable bit is 0 the flag is held clear.

Top module: `gpio_edge_pager`

## Requirements
- R1: After reset, all output latches, enables, polarities, event flags and the page register are 0. The interrupt output is 0.
- R2: A write to offset p (0 to 5) loads port p's latch, which drives pins_out[8p+7:8p]. A read of offset p returns pins_in[8p+7:8p] as seen through a two-flop synchronizer, so a read reflects the pin level two clocks late. rdata is 0 whenever rd_en is low.
- R3: A read of offset 6 returns a summary. Bit p (p = 0..2) is 1 when port p holds at least one event, and bits 7:3 read 0. Writes to offset 6 have no effect.
- R4: Offset 7 is the read/write page register. Page value 0x80 maps the enable bank onto offsets 8 to 10 (one byte per port 0..2). Value 0x40 maps the polarity bank there, and value 0xC0 maps the event bank there.
- R5: A polarity bit of 1 selects rising edges and 0 selects falling edges. An edge on a pin becomes visible as an event after the third rising clock edge following the pin change.
- R6: An event flag is set only when its line's enable bit is 1 at the time the edge is detected. An edge that occurs while the line is disabled is lost and does not appear when the line is enabled later.
- R7: An event flag stays set until it is cleared, including through later opposite edges. The interrupt output is the OR of all event flags.
- R8: Writing a line's enable bit to 0 clears that line's event flag and holds it clear. Writing the bit back to 1 re-arms detection without restoring the old event.
- R9: Reads of offsets 8 to 10 return 0 when the page value is not one of the three defined values. Writes to the window while the event page is selected change nothing. Offsets 11 to 15 read 0.
- R10: Ports 3 to 5 (lines 24 to 47) have no edge capture. Their pins never affect the summary or the interrupt output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe; rdata is valid in the same cycle |
| rdata | output | 8 | Read data, 0 when no read |
| pins_in | input | 48 | Pin levels, asynchronous |
| pins_out | output | 48 | Output latch contents |
| irq | output | 1 | High while any event is latched |

## Verification
The bench sets and clears events on lines in all three interrupt-capable ports. It confirms that a wrong polarity bit blocks the event, and that the opposite edge does not clear a sticky flag. A design that latched edges while disabled would show a stale event when the line is enabled. A design whose clear did not work through the enable bit would leave the interrupt output high after the acknowledge sequence. Further directed writes land on the event page, the summary offset and undefined page values, which a loosely decoded design would let alter the enable or polarity banks. Edges driven on the upper three ports with every enable set expose any leak of those lines into the interrupt path.

// File: rtl/gpio_edge_pager.sv
module gpio_edge_pager #(
  parameter int         NPORT     = 6,
  parameter int         IRQ_PORTS = 3,
  parameter logic [7:0] PG_EN     = 8'h80,
  parameter logic [7:0] PG_POL    = 8'h40,
  parameter logic [7:0] PG_EVT    = 8'hC0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        addr,
  input  logic [7:0]        wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [7:0]        rdata,
  input  logic [NPORT*8-1:0] pins_in,
  output logic [NPORT*8-1:0] pins_out,
  output logic              irq
);
  localparam int ADDR_SUM  = NPORT;
  localparam int ADDR_PAGE = NPORT + 1;
  localparam int ADDR_WIN  = NPORT + 2;

  logic [7:0] out_q [NPORT];
  logic [7:0] s1    [NPORT];
  logic [7:0] s2    [NPORT];
  logic [7:0] prev  [IRQ_PORTS];
  logic [7:0] en    [IRQ_PORTS];
  logic [7:0] pol   [IRQ_PORTS];
  logic [7:0] ev    [IRQ_PORTS];
  logic [7:0] hit   [IRQ_PORTS];
  logic [7:0] page;
  logic [IRQ_PORTS-1:0] summary;
  logic [IRQ_PORTS-1:0] en_any;

  always_ff @(posedge clk) begin
    if (!rst_n)                                   page <= '0;
    else if (wr_en && addr == 4'(ADDR_PAGE))      page <= wdata;
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign pins_out[8*p +: 8] = out_q[p];
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        out_q[p] <= '0;
        s1[p]    <= '0;
        s2[p]    <= '0;
      end else begin
        if (wr_en && addr == 4'(p)) out_q[p] <= wdata;
        s1[p] <= pins_in[8*p +: 8];
        s2[p] <= s1[p];
      end
    end
  end

  for (genvar p = 0; p < IRQ_PORTS; p++) begin : g_irq
    wire sel = wr_en && addr == 4'(ADDR_WIN + p);

    assign hit[p]     = (pol[p] & s2[p] & ~prev[p]) | (~pol[p] & ~s2[p] & prev[p]);
    assign summary[p] = |ev[p];
    assign en_any[p]  = |en[p];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prev[p] <= '0;
        en[p]   <= '0;
        pol[p]  <= '0;
        ev[p]   <= '0;
      end else begin
        prev[p] <= s2[p];
        ev[p]   <= en[p] & (ev[p] | hit[p]);
        if (sel && page == PG_EN)  en[p]  <= wdata;
        if (sel && page == PG_POL) pol[p] <= wdata;
      end
    end

    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(ev[p]) & $past(en[p])) & ~ev[p]) == 8'h00));

    assert_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((ev[p] & ~$past(en[p])) == 8'h00));

    assert_evt_page_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && page == PG_EVT) |=> ($stable(en[p]) && $stable(pol[p])));
  end

  assign irq = |summary;

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      for (int p = 0; p < NPORT; p++)
        if (addr == 4'(p)) rdata = s2[p];
      if (addr == 4'(ADDR_SUM))  rdata = 8'(summary);
      if (addr == 4'(ADDR_PAGE)) rdata = page;
      for (int p = 0; p < IRQ_PORTS; p++)
        if (addr == 4'(ADDR_WIN + p)) begin
          if      (page == PG_EN)  rdata = en[p];
          else if (page == PG_POL) rdata = pol[p];
          else if (page == PG_EVT) rdata = ev[p];
          else                     rdata = '0;
        end
    end
  end

  assert_irq_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en_any) == '0) |-> !irq);

  assert_summary_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 4'(ADDR_SUM)) |-> ((rdata >> IRQ_PORTS) == 8'h00));

  assert_idle_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rdata == 8'h00));
endmodule

// File: tb/sim_gpio_edge_pager.sv
`timescale 1ns/1ps
module sim_gpio_edge_pager;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  rdata;
  logic [47:0] pins = '0;
  logic [47:0] pins_out;
  logic        irq;

  int total = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  gpio_edge_pager u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .pins_in(pins), .pins_out(pins_out), .irq(irq)
  );

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic set_pins(input logic [47:0] v);
    @(negedge clk);
    pins = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    #1;
    check("R1 pins_out", pins_out, 0);
    check("R1 irq", irq, 0);
    check("R2 idle rdata", rdata, 0);
    rd(4'd7, d); check("R1 page", d, 0);
    rd(4'd6, d); check("R1 summary", d, 0);
    rd(4'd8, d); check("R9 window page0", d, 0);
  endtask

  task automatic t_ports();
    logic [7:0] d;
    logic [47:0] v = 48'h123456789ABC;
    wr(4'd0, 8'hA5); wr(4'd5, 8'h3C); wr(4'd2, 8'h0F);
    check("R2 latches", pins_out, 48'h3C00000F00A5);
    set_pins(v);
    for (int p = 0; p < 6; p++) begin
      rd(4'(p), d);
      check("R2 readback", d, v[8*p +: 8]);
    end
    set_pins('0);
  endtask

  task automatic t_page();
    logic [7:0] d;
    wr(4'd7, 8'h40); rd(4'd7, d); check("R4 page readback", d, 8'h40);
  endtask

  task automatic t_rise_clear();
    logic [7:0] d;
    wr(4'd7, 8'h80); wr(4'd8, 8'h01);
    wr(4'd7, 8'h40); wr(4'd8, 8'h01);
    set_pins(48'h1);
    wr(4'd7, 8'hC0);
    rd(4'd8, d); check("R5 rising event", d, 8'h01);
    rd(4'd6, d); check("R3 summary port0", d, 8'h01);
    check("R7 irq set", irq, 1);
    set_pins('0);
    rd(4'd8, d); check("R7 sticky on falling", d, 8'h01);
    wr(4'd7, 8'h80); wr(4'd8, 8'h00);
    wr(4'd7, 8'hC0);
    rd(4'd8, d); check("R8 cleared", d, 8'h00);
    check("R8 irq low", irq, 0);
    wr(4'd7, 8'h80); wr(4'd8, 8'h01);
    wr(4'd7, 8'hC0);
    rd(4'd8, d); check("R8 rearm no stale", d, 8'h00);
    set_pins(48'h1);
    rd(4'd8, d); check("R8 rearmed detects", d, 8'h01);
    set_pins('0);
    wr(4'd7, 8'h80); wr(4'd8, 8'h00);
  endtask

  task automatic t_fall();
    logic [7:0] d;
    wr(4'd7, 8'h80); wr(4'd9, 8'h08);
    set_pins(48'h1 << 11);
    wr(4'd7, 8'hC0);
    rd(4'd9, d); check("R5 rising ignored when falling", d, 8'h00);
    set_pins('0);
    rd(4'd9, d); check("R5 falling event", d, 8'h08);
    rd(4'd6, d); check("R3 summary port1", d, 8'h02);
    check("R7 irq port1", irq, 1);
  endtask

  task automatic t_ignored();
    logic [7:0] d;
    wr(4'd9, 8'h00);
    rd(4'd9, d); check("R9 event page write ignored", d, 8'h08);
    wr(4'd7, 8'h80); rd(4'd9, d); check("R9 enable untouched", d, 8'h08);
    wr(4'd7, 8'h40); rd(4'd8, d); check("R9 polarity untouched", d, 8'h01);
    wr(4'd7, 8'h55);
    rd(4'd9, d); check("R9 undefined page", d, 8'h00);
    rd(4'd12, d); check("R9 high offset", d, 8'h00);
    wr(4'd6, 8'hFF);
    rd(4'd6, d); check("R3 summary write ignored", d, 8'h02);
    wr(4'd7, 8'h80); wr(4'd9, 8'h00);
    wr(4'd7, 8'hC0);
    rd(4'd9, d); check("R8 port1 cleared", d, 8'h00);
    check("R8 irq low port1", irq, 0);
  endtask

  task automatic t_lost();
    logic [7:0] d;
    set_pins(48'h1 << 23); set_pins('0);
    wr(4'd7, 8'h80); wr(4'd10, 8'h80);
    wr(4'd7, 8'hC0);
    rd(4'd10, d); check("R6 disabled edge lost", d, 8'h00);
    check("R6 irq low", irq, 0);
    set_pins(48'h1 << 23); set_pins('0);
    rd(4'd10, d); check("R6 enabled edge kept", d, 8'h80);
    rd(4'd6, d); check("R3 summary port2", d, 8'h04);
    wr(4'd7, 8'h80); wr(4'd10, 8'h00);
  endtask

  task automatic t_upper();
    logic [7:0] d;
    wr(4'd7, 8'h80); wr(4'd8, 8'hFF); wr(4'd9, 8'hFF); wr(4'd10, 8'hFF);
    set_pins(48'hFFFFFF000000); set_pins('0);
    check("R10 irq untouched", irq, 0);
    rd(4'd6, d); check("R10 summary untouched", d, 8'h00);
    wr(4'd8, 8'h00); wr(4'd9, 8'h00); wr(4'd10, 8'h00);
    check("R2 latches unchanged", pins_out, 48'h3C00000F00A5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ports();
    t_page();
    t_rise_clear();
    t_fall();
    t_ignored();
    t_lost();
    t_upper();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(200000 * 5);
    total++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule